// File: doc/BRIEF.md
# Slave Port Arbiter with Idle Parking

This block decides, for one slave port of a multi-master bus matrix, which of up to eight masters owns the slave. Each master raises a request line. The arbiter answers with a one-hot grant vector and a connection-valid flag. The flag is high in any cycle where the granted master is also requesting, so a transfer can move in that cycle. The grant comes from a register. A master that finds the slave unowned, or owned by someone else, therefore waits one connection cycle before its first transfer.

When the slave falls idle, a programmable parking policy chooses what happens next. The slave can drop every connection, stay with the master that used it last, or park on one fixed master. The parked master then starts its next burst with no connection cycle.

Arbitration is by a 2-bit priority per master, where the larger value wins. Ties are broken round-robin. An optional slot limit caps how many busy cycles one master may hold the slave while others wait. The grant only moves at a beat boundary. Configuration comes through a one-cycle write port that holds two words: a slave word and a priority word.

Top module: `slave_port_arbiter`

## Requirements
- R1: After reset, grant_o and conn_o are 0, the parking mode is 0, every priority is 0 and the slot limit is 0.
- R2: grant_o has at most one bit set. conn_o is 1 in a cycle exactly when the master whose grant bit is set has its request high.
- R3: Writing the slave word uses cfg_sel_i=0, with the mode in bits [17:16]. With mode 0, a last beat (beat_done_i and burst_last_i both high) with no other request pending clears grant_o in the next cycle. A master that requests while nothing is granted sees conn_o=0 in its first request cycle and gets its grant bit in the following cycle.
- R4: With mode 1, the slave stays granted to the last owner after its last beat and while nobody requests. That owner gets conn_o=1 in the first cycle it requests again.
- R5: With mode 2, an idle slave with no request parks in the next cycle on the master whose index is in slave-word bits [20:18], when that index is below NM. That master gets conn_o=1 in its first request cycle. Any other master waits one cycle.
- R6: Writing the priority word uses cfg_sel_i=1. Master m's priority is in bits [4m+1:4m]. Among competing requesters, the highest value wins.
- R7: Requesters of equal top priority are served in round-robin order. The order starts at the index after the most recently granted master and wraps.
- R8: Slot limit L is in slave-word bits [7:0]. With L>0, once the owner has held the slave for L busy cycles, a completing beat hands the slave to another requester, and the grant moves in the next cycle. If no other master is requesting, the owner keeps the slave. L=0 means no limit.
- R9: While the granted master is requesting, grant_o changes only in the cycle after a completed beat that is either the last of its burst or at the slot limit.
- R10: Mode 3 behaves exactly like mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_i | input | NM | Request line per master |
| beat_done_i | input | 1 | The owner's current beat completes this cycle |
| burst_last_i | input | 1 | The completing beat is the last of the owner's access |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 1 | 0 selects the slave word, 1 selects the priority word |
| cfg_wdata_i | input | CFG_W | Configuration write data |
| grant_o | output | NM | One-hot grant, all zero when disconnected |
| conn_o | output | 1 | The granted master is requesting, so a transfer can proceed |

## Verification
The slot-limit handover is the hardest situation to reach. It needs one master held busy with a beat completing every cycle while a rival's request stays raised the whole time, and the counter must reach the limit before any last beat arrives. The bench sets a small limit and streams beats without ever asserting the last-beat flag. It then times the exact cycle where the grant swaps. A second pass keeps the limit already expired while beats are withheld, to show that the grant holds until a beat completes. The parking cases follow the same pattern: a configuration write is landed while no master requests, and the first cycle of the next request is sampled to see whether a connection cycle is paid.

// File: rtl/spa_pkg.sv
`timescale 1ns/1ps
// Package: shared encodings and field positions for the slave port arbiter.
// Assumes a configuration word of at least 21 bits for the slave word and
// 4*NM bits for the priority word.
package spa_pkg;

    typedef enum logic [1:0] {
        PARK_NONE  = 2'd0,
        PARK_LAST  = 2'd1,
        PARK_FIXED = 2'd2,
        PARK_RSVD  = 2'd3
    } park_mode_e;

    localparam int SLOT_LSB    = 0;
    localparam int SLOT_W      = 8;
    localparam int MODE_LSB    = 16;
    localparam int MODE_W      = 2;
    localparam int FIX_LSB     = 18;
    localparam int FIX_W       = 3;
    localparam int PRIO_STRIDE = 4;
    localparam int PRIO_W      = 2;

endpackage

// File: rtl/spa_cfg_regs.sv
`timescale 1ns/1ps
// Module: configuration store of the arbiter. Holds the parking mode, the
// fixed park index, the slot limit and one priority per master.
// Assumes single-cycle writes; cfg_sel selects slave word (0) or priority word (1).
module spa_cfg_regs
    import spa_pkg::*;
#(
    parameter int NM    = 8,
    parameter int CFG_W = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic                   sel,
    input  logic [CFG_W-1:0]       wdata,
    output park_mode_e             mode,
    output logic [FIX_W-1:0]       fixed_idx,
    output logic [SLOT_W-1:0]      slot_lim,
    output logic [NM*PRIO_W-1:0]   prio
);

    logic cfg_unused;
    assign cfg_unused = ^wdata;

    // Slave word: mode, fixed index and slot limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode      <= PARK_NONE;
            fixed_idx <= '0;
            slot_lim  <= '0;
        end else if (we && !sel) begin
            mode      <= park_mode_e'(wdata[MODE_LSB +: MODE_W]);
            fixed_idx <= wdata[FIX_LSB +: FIX_W];
            slot_lim  <= wdata[SLOT_LSB +: SLOT_W];
        end
    end

    // Priority word: one field per master at a fixed stride.
    for (genvar g = 0; g < NM; g++) begin : g_prio
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                prio[g*PRIO_W +: PRIO_W] <= '0;
            end else if (we && sel) begin
                prio[g*PRIO_W +: PRIO_W] <= wdata[g*PRIO_STRIDE +: PRIO_W];
            end
        end
    end

endmodule

// File: rtl/spa_pick.sv
`timescale 1ns/1ps
// Module: combinational winner selection. Highest priority among the
// candidates wins; ties go to the first candidate in round-robin order
// starting one index after ptr. Assumes ptr < NM.
module spa_pick
    import spa_pkg::*;
#(
    parameter int NM = 8,
    parameter int IW = 3
) (
    input  logic [NM-1:0]         cand,
    input  logic [NM*PRIO_W-1:0]  prio,
    input  logic [IW-1:0]         ptr,
    output logic                  found,
    output logic [IW-1:0]         win
);

    logic [PRIO_W-1:0] pr [NM];

    for (genvar g = 0; g < NM; g++) begin : g_unpack
        assign pr[g] = prio[g*PRIO_W +: PRIO_W];
    end

    // Rotating scan; a strictly larger priority replaces the current best.
    always_comb begin
        logic [PRIO_W-1:0] best;
        found = 1'b0;
        win   = ptr;
        best  = '0;
        for (int off = 1; off <= NM; off++) begin
            logic [IW-1:0] idx;
            idx = IW'((int'(ptr) + off) % NM);
            if (cand[idx] && (!found || pr[idx] > best)) begin
                found = 1'b1;
                win   = idx;
                best  = pr[idx];
            end
        end
    end

endmodule

// File: rtl/spa_slot_timer.sv
`timescale 1ns/1ps
// Module: counts busy cycles of the current owner and flags when the slot
// limit is reached. A limit of zero never expires. Assumes restart is only
// raised in busy cycles.
module spa_slot_timer #(
    parameter int SLOT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic              restart,
    input  logic [SLOT_W-1:0] limit,
    output logic              expired
);

    logic [SLOT_W-1:0] cnt_q;

    // Busy-cycle counter: cleared when idle or on restart, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!busy || restart) begin
            cnt_q <= '0;
        end else if (cnt_q != '1) begin
            cnt_q <= cnt_q + SLOT_W'(1);
        end
    end

    assign expired = (limit != '0) && (cnt_q >= limit - SLOT_W'(1));

endmodule

// File: rtl/slave_port_arbiter.sv
`timescale 1ns/1ps
// Module: per-slave arbiter of a bus matrix. Grants one of NM masters the
// slave, reopens arbitration only at a beat boundary (burst end or slot
// expiry), and applies a parking policy when the slave is idle.
// Assumes NM <= 8 and CFG_W >= max(21, 4*NM); beat_done_i/burst_last_i
// refer to the currently granted master.
module slave_port_arbiter
    import spa_pkg::*;
#(
    parameter int NM    = 8,
    parameter int CFG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NM-1:0]    req_i,
    input  logic             beat_done_i,
    input  logic             burst_last_i,
    input  logic             cfg_we_i,
    input  logic             cfg_sel_i,
    input  logic [CFG_W-1:0] cfg_wdata_i,
    output logic [NM-1:0]    grant_o,
    output logic             conn_o
);

    localparam int IW = (NM > 1) ? $clog2(NM) : 1;

    park_mode_e             cfg_mode;
    logic [FIX_W-1:0]       cfg_fixed;
    logic [SLOT_W-1:0]      cfg_slot;
    logic [NM*PRIO_W-1:0]   cfg_prio;

    logic [IW-1:0] own_q, own_d;
    logic          vld_q, vld_d;
    logic [NM-1:0] own_oh;
    logic          busy, slot_exp, reopen;
    logic [NM-1:0] cand;
    logic          pick_found;
    logic [IW-1:0] pick_win;
    logic          park_vld;
    logic [IW-1:0] park_own;

    spa_cfg_regs #(.NM(NM), .CFG_W(CFG_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (cfg_we_i),
        .sel       (cfg_sel_i),
        .wdata     (cfg_wdata_i),
        .mode      (cfg_mode),
        .fixed_idx (cfg_fixed),
        .slot_lim  (cfg_slot),
        .prio      (cfg_prio)
    );

    assign own_oh = vld_q ? (NM'(1) << own_q) : '0;
    assign busy   = vld_q && req_i[own_q];
    assign reopen = busy && beat_done_i && (burst_last_i || slot_exp);
    // While busy the owner never competes against itself.
    assign cand   = busy ? (req_i & ~own_oh) : req_i;

    spa_slot_timer #(.SLOT_W(SLOT_W)) u_slot (
        .clk     (clk),
        .rst_n   (rst_n),
        .busy    (busy),
        .restart (reopen),
        .limit   (cfg_slot),
        .expired (slot_exp)
    );

    spa_pick #(.NM(NM), .IW(IW)) u_pick (
        .cand  (cand),
        .prio  (cfg_prio),
        .ptr   (own_q),
        .found (pick_found),
        .win   (pick_win)
    );

    // Parking target for an idle slave under the current mode.
    always_comb begin
        park_own = own_q;
        park_vld = 1'b0;
        case (cfg_mode)
            PARK_LAST: begin
                park_vld = vld_q;
            end
            PARK_FIXED: begin
                if (int'(cfg_fixed) < NM) begin
                    park_vld = 1'b1;
                    park_own = IW'(cfg_fixed);
                end
            end
            default: begin
                park_vld = 1'b0;
            end
        endcase
    end

    // Next owner: hold in mid-burst, hand over or park at boundaries.
    always_comb begin
        own_d = own_q;
        vld_d = vld_q;
        if (busy) begin
            if (reopen) begin
                if (pick_found) begin
                    own_d = pick_win;
                    vld_d = 1'b1;
                end else if (burst_last_i) begin
                    own_d = park_own;
                    vld_d = park_vld;
                end
            end
        end else if (pick_found) begin
            own_d = pick_win;
            vld_d = 1'b1;
        end else begin
            own_d = park_own;
            vld_d = park_vld;
        end
    end

    // Owner register; the index is kept while disconnected as the RR pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            own_q <= '0;
            vld_q <= 1'b0;
        end else begin
            own_q <= own_d;
            vld_q <= vld_d;
        end
    end

    assign grant_o = own_oh;
    assign conn_o  = busy;

endmodule

// File: rtl/slave_port_arbiter_chk.sv
`timescale 1ns/1ps
// Module: protocol checker for slave_port_arbiter, attached by bind.
// Observes ports plus the stored mode and fixed index.
module slave_port_arbiter_chk #(
    parameter int NM = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [NM-1:0] req_i,
    input logic          beat_done_i,
    input logic          burst_last_i,
    input logic [NM-1:0] grant_o,
    input logic          conn_o,
    input logic [1:0]    mode,
    input logic [2:0]    fixed
);

    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (grant_o == '0));

    assert_grant_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));

    assert_conn_needs_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
        conn_o |-> ((grant_o & req_i) != '0));

    assert_drop_on_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (conn_o && beat_done_i && burst_last_i && ((req_i & ~grant_o) == '0)
         && (mode == 2'd0 || mode == 2'd3)) |=> (grant_o == '0));

    assert_keep_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (conn_o && beat_done_i && burst_last_i && ((req_i & ~grant_o) == '0)
         && mode == 2'd1) |=> $stable(grant_o));

    assert_park_fixed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2 && !conn_o && req_i == '0 && int'(fixed) < NM)
        |=> (grant_o == (NM'(1) << $past(fixed))));

    assert_hold_mid_beat_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (conn_o && !beat_done_i) |=> $stable(grant_o));

endmodule

bind slave_port_arbiter slave_port_arbiter_chk #(.NM(NM)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_i        (req_i),
    .beat_done_i  (beat_done_i),
    .burst_last_i (burst_last_i),
    .grant_o      (grant_o),
    .conn_o       (conn_o),
    .mode         (cfg_mode),
    .fixed        (cfg_fixed)
);

// File: tb/slave_port_arbiter_tb.sv
`timescale 1ns/1ps
module slave_port_arbiter_tb;

    localparam int NM = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NM-1:0] req;
    logic          bd, bl;
    logic          we, sel;
    logic [31:0]   wdata;
    logic [NM-1:0] grant;
    logic          conn;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    slave_port_arbiter #(.NM(NM), .CFG_W(32)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_i        (req),
        .beat_done_i  (bd),
        .burst_last_i (bl),
        .cfg_we_i     (we),
        .cfg_sel_i    (sel),
        .cfg_wdata_i  (wdata),
        .grant_o      (grant),
        .conn_o       (conn)
    );

    // {req, beat_done, burst_last, expected grant, expected conn}; mode 0, equal priority
    localparam logic [18:0] TBL [0:10] = '{
        {8'h00, 1'b0, 1'b0, 8'h00, 1'b0},
        {8'h04, 1'b0, 1'b0, 8'h00, 1'b0},
        {8'h04, 1'b1, 1'b0, 8'h04, 1'b1},
        {8'h04, 1'b1, 1'b1, 8'h04, 1'b1},
        {8'h04, 1'b0, 1'b0, 8'h00, 1'b0},
        {8'h24, 1'b1, 1'b1, 8'h04, 1'b1},
        {8'h24, 1'b1, 1'b1, 8'h20, 1'b1},
        {8'h21, 1'b0, 1'b0, 8'h04, 1'b0},
        {8'h21, 1'b1, 1'b1, 8'h20, 1'b1},
        {8'h00, 1'b0, 1'b0, 8'h01, 1'b0},
        {8'h00, 1'b0, 1'b0, 8'h00, 1'b0}
    };

    task automatic chk(input string what, input logic [7:0] got, input logic [7:0] exp);
        total++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", what, got, exp);
        end
    endtask

    // Drive inputs away from the edge, then settle before sampling.
    task automatic drive(input logic [NM-1:0] r, input logic d, input logic l);
        @(negedge clk);
        req = r; bd = d; bl = l;
        #1;
    endtask

    task automatic cfg_write(input logic s, input logic [31:0] d);
        @(negedge clk);
        req = '0; bd = 1'b0; bl = 1'b0;
        we = 1'b1; sel = s; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog (all requirements) actual=running expected=finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; req = '0; bd = 1'b0; bl = 1'b0;
        we = 1'b0; sel = 1'b0; wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, nothing granted even with all requesting
        drive(8'hFF, 1'b0, 1'b0);
        chk("R1 reset grant", grant, 8'h00);
        chk("R1 reset conn", {7'b0, conn}, 8'h00);
        // Back to idle so the table starts disconnected with pointer 0
        req = '0;
        @(negedge clk);
        cfg_write(1'b0, 32'h0000_0000);

        // Table: R2 conn, R3 connection cycle, R7 round-robin, R9 hold
        for (int i = 0; i < 11; i++) begin
            drive(TBL[i][18:11], TBL[i][10], TBL[i][9]);
            chk($sformatf("R2/R3/R7/R9 table step %0d grant", i), grant, TBL[i][8:1]);
            chk($sformatf("R2/R3/R7/R9 table step %0d conn", i), {7'b0, conn}, {7'b0, TBL[i][0]});
        end

        // R4: last-owner parking
        cfg_write(1'b0, 32'h0001_0000);
        drive(8'h08, 1'b0, 1'b0);
        chk("R4 first request pays a cycle", {7'b0, conn}, 8'h00);
        drive(8'h08, 1'b1, 1'b1);
        chk("R4 granted", grant, 8'h08);
        drive(8'h00, 1'b0, 1'b0);
        chk("R4 stays after burst", grant, 8'h08);
        drive(8'h00, 1'b0, 1'b0);
        chk("R4 stays while idle", grant, 8'h08);
        drive(8'h08, 1'b0, 1'b0);
        chk("R4 return without connect cycle", {7'b0, conn}, 8'h01);
        drive(8'h08, 1'b1, 1'b1);

        // R5: fixed parking on master 6 (mode 2, index 6 in bits 20:18)
        cfg_write(1'b0, 32'h001A_0000);
        drive(8'h00, 1'b0, 1'b0);
        chk("R5 parked on fixed", grant, 8'h40);
        drive(8'h40, 1'b1, 1'b1);
        chk("R5 fixed master no connect cycle", {7'b0, conn}, 8'h01);
        drive(8'h02, 1'b0, 1'b0);
        chk("R5 other master pays a cycle", {7'b0, conn}, 8'h00);
        drive(8'h02, 1'b1, 1'b1);
        chk("R5 other master granted", grant, 8'h02);
        drive(8'h00, 1'b0, 1'b0);
        chk("R5 back on fixed", grant, 8'h40);

        // R10: reserved mode disconnects like mode 0
        cfg_write(1'b0, 32'h0003_0000);
        drive(8'h00, 1'b0, 1'b0);
        chk("R10 reserved mode disconnects", grant, 8'h00);
        drive(8'h10, 1'b0, 1'b0);
        chk("R10 connect cycle", {7'b0, conn}, 8'h00);
        drive(8'h10, 1'b1, 1'b1);
        chk("R10 granted", grant, 8'h10);
        drive(8'h00, 1'b0, 1'b0);
        chk("R10 dropped after burst", grant, 8'h00);

        // R6: master 1 priority 3, master 4 priority 1, others 0
        cfg_write(1'b0, 32'h0000_0000);
        cfg_write(1'b1, 32'h0001_0030);
        drive(8'h92, 1'b0, 1'b0);
        drive(8'h92, 1'b1, 1'b1);
        chk("R6 highest priority wins", grant, 8'h02);
        drive(8'h90, 1'b1, 1'b1);
        chk("R6 next priority wins", grant, 8'h10);
        drive(8'h80, 1'b1, 1'b1);
        chk("R6 lowest last", grant, 8'h80);
        drive(8'h00, 1'b0, 1'b0);
        cfg_write(1'b1, 32'h0000_0000);

        // R8: slot limit 3 with two masters streaming beats
        cfg_write(1'b0, 32'h0000_0003);
        drive(8'h05, 1'b1, 1'b0);
        for (int k = 0; k < 3; k++) begin
            drive(8'h05, 1'b1, 1'b0);
            chk($sformatf("R8 first owner slot cycle %0d", k), grant, 8'h01);
        end
        for (int k = 0; k < 3; k++) begin
            drive(8'h05, 1'b1, 1'b0);
            chk($sformatf("R8 second owner slot cycle %0d", k), grant, 8'h04);
        end
        drive(8'h01, 1'b1, 1'b0);
        chk("R8 slot returns", grant, 8'h01);
        for (int k = 0; k < 6; k++) begin
            drive(8'h01, 1'b1, 1'b0);
            chk($sformatf("R8 lone owner keeps past limit %0d", k), grant, 8'h01);
        end
        drive(8'h01, 1'b1, 1'b1);
        drive(8'h00, 1'b0, 1'b0);

        // R9: slot limit 1 already reached, no beat completes
        cfg_write(1'b0, 32'h0000_0001);
        drive(8'h01, 1'b0, 1'b0);
        for (int k = 0; k < 3; k++) begin
            drive(8'h05, 1'b0, 1'b0);
            chk($sformatf("R9 no handover mid-beat %0d", k), grant, 8'h01);
        end
        drive(8'h05, 1'b1, 1'b0);
        chk("R9 owner until beat ends", grant, 8'h01);
        drive(8'h05, 1'b0, 1'b0);
        chk("R8 handover after beat end", grant, 8'h04);
        drive(8'h00, 1'b0, 1'b0);

        // R8: limit 0 means unlimited
        cfg_write(1'b0, 32'h0000_0000);
        drive(8'h05, 1'b1, 1'b0);
        for (int k = 0; k < 10; k++) begin
            drive(8'h05, 1'b1, 1'b0);
            chk($sformatf("R8 no limit cycle %0d", k), grant, 8'h01);
        end
        drive(8'h00, 1'b0, 1'b0);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule